// File: doc/BRIEF.md
# Translation Cache with Two-Level Page Walker

This block turns a 32-bit virtual address into a physical one for a single aligned four-byte read made at User privilege, then fetches the word. It first searches a small set-associative translation cache. On a miss it reads a directory entry and then a table entry from memory, checking at each step that the entry is present and open to User code.

The block returns one of two outcomes. On success it gives the physical address and the data word. On failure it gives a three-bit code that names the level at which the walk stopped and the cause. A separate flag always says whether the cache hit. A successful walk installs its table entry in the cache so that a later access to the same page hits.

Requests use a plain handshake: `req` is taken only while the block is idle, and `done` answers every accepted request. Memory is a single synchronous read port that returns data in the cycle after the read strobe.

Top module: `tlb_walker`

## Requirements
- R1: While reset is held and after it is released, `done` and `mem_rd` are low, and the translation cache is empty, so the first access to any page reports a miss.
- R2: A walk reads the directory entry at {`dir_base`[31:12], VA[31:22], 2'b00}, then reads the table entry at {directory entry[31:12], VA[21:12], 2'b00}. Every `mem_addr` presented with `mem_rd` has its two low bits at zero.
- R3: In any entry, bit 0 marks it present and bit 2 marks it usable by User code. `fault_code` bit 2 flags a failure, bit 1 gives the level (0 directory, 1 table) and bit 0 gives the cause (0 not present, 1 protection). On success the code is 3'b000.
- R4: A directory entry with bit 0 clear gives code 3'b100, even when its bit 2 is set. One with bit 0 set and bit 2 clear gives 3'b101.
- R5: A table entry with bit 0 clear gives code 3'b110. One with bit 0 set and bit 2 clear gives 3'b111.
- R6: On success, `paddr` is {table entry[31:20... i.e. bits 31:12], VA[11:0]} and `rdata` is the memory word at `paddr`.
- R7: `hit` is 1 when a valid cache way in set VA[14:12] holds tag VA[31:15]. A successful walk installs its entry. A faulting walk installs nothing, so a repeated faulting access misses again. A hit never reports a fault.
- R8: The cache has 8 sets of 4 ways. A fill takes the lowest-numbered invalid way of its set. When all four ways are valid, it replaces the way named by a per-set round-robin pointer that starts at way 0 and advances after each replacement.
- R9: Count the edge that accepts `req` as edge 1. `done` is high for the cycle after edge 3 on a hit or a directory fault, after edge 4 on a table fault, and after edge 5 on a successful walk.
- R10: `done` is high for one cycle per accepted request. A `req` raised while a request is in progress is ignored, and the results belong to the accepted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 32 | Physical base of the page directory (bits 31:12 used) |
| req | input | 1 | Request strobe, taken when idle |
| vaddr | input | 32 | Virtual address of the four-byte read |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Translation cache hit, valid with done |
| fault_code | output | 3 | {fault, level, protection}, valid with done |
| paddr | output | 32 | Translated physical address, valid with done on success |
| rdata | output | 32 | Data word read, valid with done on success |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Memory data, one cycle after the strobe |

## Verification
Each result is due a fixed number of edges after the accepting edge: three for a hit or a directory fault, four for a table fault and five for a full walk. The bench counts edges from the accepting edge until `done` and compares that count with the figure for the expected outcome. The outputs are sampled on the falling edge in which `done` is high, and the next request is raised only after the block has returned to idle. An in-flight request is probed again at a fixed edge, and `done` is then watched for several quiet cycles, so that a stray extra completion is caught.

// File: rtl/tlb_walker.sv
module tlb_walker #(
  parameter int SETS = 8,
  parameter int WAYS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] dir_base,
  input  logic        req,
  input  logic [31:0] vaddr,
  output logic        done,
  output logic        hit,
  output logic [2:0]  fault_code,
  output logic [31:0] paddr,
  output logic [31:0] rdata,
  output logic        mem_rd,
  output logic [31:0] mem_addr,
  input  logic [31:0] mem_rdata
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = 20 - SET_W;
  localparam int P_BIT = 0;
  localparam int U_BIT = 2;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_DIR, S_TBL, S_DATA, S_DONE} st_t;

  st_t st;
  logic [31:0] va_q;
  logic        hit_q;
  logic [2:0]  flt_q;
  logic [31:0] pa_q, rd_q;

  logic [TAG_W-1:0] tag_a [SETS][WAYS];
  logic [31:0]      ent_a [SETS][WAYS];
  logic [WAYS-1:0]  vld   [SETS];
  logic [WAY_W-1:0] rr    [SETS];

  wire [SET_W-1:0] vset = va_q[12 +: SET_W];
  wire [TAG_W-1:0] vtag = va_q[31 -: TAG_W];
  wire             e_ok = mem_rdata[P_BIT] & mem_rdata[U_BIT];

  logic             lk_hit;
  logic [WAY_W-1:0] lk_way;
  logic [WAY_W-1:0] vic;
  logic             vic_free;

  always_comb begin
    lk_hit = 1'b0;
    lk_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (!lk_hit && vld[vset][w] && tag_a[vset][w] == vtag) begin
        lk_hit = 1'b1;
        lk_way = WAY_W'(w);
      end
  end

  always_comb begin
    vic      = rr[vset];
    vic_free = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (!vic_free && !vld[vset][w]) begin
        vic      = WAY_W'(w);
        vic_free = 1'b1;
      end
  end

  wire [31:0] hit_pa  = {ent_a[vset][lk_way][31:12], va_q[11:0]};
  wire [31:0] dir_pa  = {dir_base[31:12], va_q[31:22], 2'b00};
  wire [31:0] tbl_pa  = {mem_rdata[31:12], va_q[21:12], 2'b00};
  wire [31:0] dat_pa  = {mem_rdata[31:12], va_q[11:0]};

  always_comb begin
    mem_rd   = 1'b0;
    mem_addr = '0;
    case (st)
      S_LOOK: begin mem_rd = 1'b1; mem_addr = lk_hit ? hit_pa : dir_pa; end
      S_DIR:  begin mem_rd = e_ok; mem_addr = e_ok ? tbl_pa : '0; end
      S_TBL:  begin mem_rd = e_ok; mem_addr = e_ok ? dat_pa : '0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      va_q  <= '0;
      hit_q <= 1'b0;
      flt_q <= '0;
      pa_q  <= '0;
      rd_q  <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        rr[s]  <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (req) begin
          va_q  <= vaddr;
          hit_q <= 1'b0;
          flt_q <= '0;
          pa_q  <= '0;
          rd_q  <= '0;
          st    <= S_LOOK;
        end
        S_LOOK: begin
          hit_q <= lk_hit;
          if (lk_hit) begin
            pa_q <= hit_pa;
            st   <= S_DATA;
          end else begin
            st <= S_DIR;
          end
        end
        S_DIR: begin
          if (e_ok) st <= S_TBL;
          else begin
            flt_q <= {1'b1, 1'b0, mem_rdata[P_BIT]};
            st    <= S_DONE;
          end
        end
        S_TBL: begin
          if (e_ok) begin
            pa_q               <= dat_pa;
            tag_a[vset][vic]   <= vtag;
            ent_a[vset][vic]   <= mem_rdata;
            vld[vset][vic]     <= 1'b1;
            if (!vic_free) rr[vset] <= rr[vset] + 1'b1;
            st <= S_DATA;
          end else begin
            flt_q <= {1'b1, 1'b1, mem_rdata[P_BIT]};
            st    <= S_DONE;
          end
        end
        S_DATA: begin
          rd_q <= mem_rdata;
          st   <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done       = (st == S_DONE);
  assign hit        = hit_q;
  assign fault_code = flt_q;
  assign paddr      = pa_q;
  assign rdata      = rd_q;
endmodule

// File: rtl/tlb_walker_chk.sv
module tlb_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic [31:0] vaddr,
  input logic        done,
  input logic        hit,
  input logic [2:0]  fault_code,
  input logic [31:0] paddr,
  input logic        mem_rd,
  input logic [31:0] mem_addr
);
  logic        busy;
  logic [31:0] va_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      va_c <= '0;
    end else if (!busy && req) begin
      busy <= 1'b1;
      va_c <= vaddr;
    end else if (done) begin
      busy <= 1'b0;
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  done_owner_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
  // R2
  rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (busy && mem_addr[1:0] == 2'b00));
  // R6
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_code == 3'b000) |-> paddr[11:0] == va_c[11:0]);
  // R7
  hit_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> fault_code == 3'b000);
  // R3
  code_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault_code[2]) |-> fault_code[1:0] == 2'b00);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!done && !mem_rd));
endmodule

bind tlb_walker tlb_walker_chk u_chk (.*);

// File: tb/tlb_walker_tb.sv
module tlb_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dir_base = 32'h0000_4000;
  logic        req = 1'b0;
  logic [31:0] vaddr = '0;
  logic        done, hit, mem_rd;
  logic [2:0]  fault_code;
  logic [31:0] paddr, rdata, mem_addr;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tlb_walker u_dut (.*);

  function automatic [31:0] dir_ent(input int d);
    if (d < 5)       return 32'h0000_1007;
    else if (d == 5) return 32'h0000_1004;
    else if (d == 6) return 32'h0000_1001;
    else if (d == 7) return 32'h0000_2007;
    else             return 32'h0;
  endfunction

  function automatic [31:0] dataf(input [31:0] a);
    return (a * 32'h0001_0003) ^ 32'h5A5A_C3C3;
  endfunction

  function automatic [31:0] memf(input [31:0] a);
    int t = int'(a[11:2]);
    case (a[31:12])
      20'h4: return dir_ent(t);
      20'h1: begin
        if (t % 8 == 3)      return ((32'h100 + t) << 12) | 32'h4;
        else if (t % 8 == 5) return ((32'h100 + t) << 12) | 32'h1;
        else                 return ((32'h100 + t) << 12) | 32'h7;
      end
      20'h2: return ((32'h200 + t) << 12) | 32'h7;
      default: return dataf(a);
    endcase
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

  logic [16:0] mt_tag [8][4];
  bit          mt_v   [8][4];
  int          mt_rr  [8];

  task automatic mt_clear();
    for (int s = 0; s < 8; s++) begin
      mt_rr[s] = 0;
      for (int w = 0; w < 4; w++) mt_v[s][w] = 1'b0;
    end
  endtask

  function automatic bit mt_look(input [31:0] va);
    for (int w = 0; w < 4; w++)
      if (mt_v[va[14:12]][w] && mt_tag[va[14:12]][w] == va[31:15]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic mt_fill(input [31:0] va);
    int s = int'(va[14:12]);
    int v = -1;
    for (int w = 0; w < 4; w++) if (v < 0 && !mt_v[s][w]) v = w;
    if (v < 0) begin v = mt_rr[s]; mt_rr[s] = (mt_rr[s] + 1) % 4; end
    mt_v[s][v] = 1'b1;
    mt_tag[s][v] = va[31:15];
  endtask

  task automatic check(input bit ok, input string rq, input string what,
                       input [31:0] act, input [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req = 1'b0;
    mt_clear();
    repeat (3) @(negedge clk);
    check(!done && !mem_rd, "R1", "outputs in reset", {30'b0, done, mem_rd}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !mem_rd, "R1", "outputs after reset", {30'b0, done, mem_rd}, 32'h0);
  endtask

  task automatic run(input [31:0] va, input string rtag);
    logic [2:0]  ef;
    logic [31:0] de, te, ep, ed;
    bit eh;
    int el, lat;
    string ftag;
    de = dir_ent(int'(va[31:22]));
    ep = '0; ed = '0;
    if (!de[0])      ef = 3'b100;
    else if (!de[2]) ef = 3'b101;
    else begin
      te = memf({de[31:12], va[21:12], 2'b00});
      if (!te[0])      ef = 3'b110;
      else if (!te[2]) ef = 3'b111;
      else begin ef = 3'b000; ep = {te[31:12], va[11:0]}; ed = dataf(ep); end
    end
    eh = mt_look(va);
    if (eh) el = 3;
    else if (ef[2] && !ef[1]) el = 3;
    else if (ef[2]) el = 4;
    else el = 5;
    ftag = (ef == 3'b000) ? "R6" : (ef[1] ? "R5" : "R4");

    @(negedge clk);
    req = 1'b1; vaddr = va; lat = 0;
    @(posedge clk); lat = 1;
    @(negedge clk); req = 1'b0;
    while (!done && lat < 20) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    check(fault_code == ef, ftag, "fault code", {29'b0, fault_code}, {29'b0, ef});
    check(hit == eh, rtag, "hit flag", {31'b0, hit}, {31'b0, eh});
    check(lat == el, "R9", "latency", lat, el);
    if (ef == 3'b000) begin
      check(paddr == ep, "R6", "paddr", paddr, ep);
      check(rdata == ed, "R6", "rdata", rdata, ed);
      if (!eh) mt_fill(va);
    end
  endtask

  initial begin
    do_reset();
    // R2 R3 R4 R5 R6 R7: sweep directory and table slots, each page twice
    for (int d = 0; d < 8; d++)
      for (int t = 0; t < 16; t++) begin
        logic [31:0] va;
        va = {d[9:0], t[9:0], 12'(((d * 37 + t * 11) & 32'h3ff) << 2)};
        run(va, "R7");
        run(va ^ 32'h0000_0ff0, "R7");
      end

    // R8: replacement order in set 0
    do_reset();
    for (int d = 0; d < 5; d++) run({d[9:0], 10'd0, 12'h010}, "R8");
    run({10'd1, 10'd0, 12'h020}, "R8");
    run({10'd0, 10'd0, 12'h030}, "R8");
    run({10'd1, 10'd0, 12'h040}, "R8");
    run({10'd2, 10'd0, 12'h050}, "R8");

    // R10: request raised while busy is ignored
    do_reset();
    @(negedge clk);
    req = 1'b1; vaddr = {10'd1, 10'd2, 12'h100};
    @(negedge clk);
    vaddr = {10'd5, 10'd0, 12'h0};
    @(negedge clk);
    req = 1'b0;
    begin
      int guard = 0;
      while (!done && guard < 20) begin @(negedge clk); guard++; end
    end
    check(fault_code == 3'b000, "R10", "first request kept", {29'b0, fault_code}, 32'h0);
    check(paddr == {20'h102, 12'h100}, "R10", "paddr of first", paddr, {20'h102, 12'h100});
    begin
      int extra = 0;
      for (int i = 0; i < 8; i++) begin @(negedge clk); if (done) extra++; end
      check(extra == 0, "R10", "no second done", extra, 0);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule